// File: doc/BRIEF.md
# Seven-to-one LVDS pixel serializer

This block turns one parallel pixel (8-bit red, green and blue plus horizontal sync, vertical sync and data enable) into seven serial bit slots on each of four LVDS data lanes and on a clock lane. It runs on the serial bit clock, seven cycles per pixel period, and models the high-rate shift stage of a flat-panel transmitter ahead of the PLL and analog drivers. It raises `pix_strobe` for one cycle in every seven; the pixel inputs and every configuration input are sampled in that cycle, and slot 0 of that pixel leaves on the following cycle.

Two colour-bit mappings are offered: the standard mapping, where the six upper bits of each colour ride on lanes 0 to 2 and the two lowest bits on lane 3, and the alternative mapping, where lane 3 carries the two top bits. An 18-bit mode drives only three lanes. Sync and enable polarity, the order of the physical data lanes and per-lane inversion (used for boards where a pair's P and N wires are crossed) are all configurable. An ordered dither can round the 8-bit colours down to six bits in 18-bit mode.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While `rst_n` is low, every data lane, the clock lane and `pix_strobe` are 0. After release, `pix_strobe` first rises in the 7th cycle, and the outputs stay 0 until the cycle after it.
- R2: `pix_strobe` is high in exactly one cycle in seven. The inputs sampled in that cycle leave as slots 0 to 6 on the next seven cycles, one slot per cycle.
- R3: With transmission enabled, the clock lane carries the slot sequence 1,1,0,0,0,1,1 for each pixel, so it is high for four of the seven slots.
- R4: Standard mapping, 24-bit (`fmt_alt`=0, `depth_18`=0). Slots 0 to 6 are: lane 0 R2,R3,R4,R5,R6,R7,G2; lane 1 G3,G4,G5,G6,G7,B2,B3; lane 2 B4,B5,B6,B7,HS,VS,DE; lane 3 R0,R1,G0,G1,B0,B1,0.
- R5: Alternative mapping, 24-bit (`fmt_alt`=1). Same slot positions as R4, but the six-bit colour fields are bits [5:0] (lane 0 R0..R5,G0; lane 1 G1..G5,B0,B1; lane 2 B2..B5,HS,VS,DE). Lane 3 carries R6,R7,G6,G7,B6,B7,0.
- R6: With `depth_18`=1, lanes 0 to 2 use the R4 layout with each colour's upper six bits, whatever `fmt_alt` is. Physical lane 3 is held at 0.
- R7: Each serialized control bit is inverted when its bit of `sync_pol` is set: bit 0 inverts HS, bit 1 inverts VS, bit 2 inverts DE.
- R8: Physical lane k carries the mapped lane chosen by `lane_order[2k+1:2k]`. The value 0xE4 is the identity.
- R9: When `lane_inv[k]` is 1, every slot of physical lane k is inverted, and this is applied after the reordering.
- R10: With `depth_18`=1 and `dither_en`=1, each colour becomes min(63, C[7:2] + (C[1:0] > t)). The threshold t is 0,2,1,3 for the 1st, 2nd, 3rd, 4th (repeating) pixel of a run with DE high; a pixel sampled with DE low restarts the run. In 24-bit mode `dither_en` has no effect.
- R11: A pixel sampled with `tx_en`=0 puts 0 on all four data lanes and the clock lane for its seven slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, seven cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmission enable |
| fmt_alt | input | 1 | 0 = standard bit mapping, 1 = alternative mapping |
| depth_18 | input | 1 | 1 = three-lane 18-bit mode |
| dither_en | input | 1 | Enable the 8-to-6-bit dither in 18-bit mode |
| sync_pol | input | 3 | Inversion of HS (bit 0), VS (bit 1) and DE (bit 2) |
| lane_order | input | 8 | Two-bit source selector for each physical lane |
| lane_inv | input | 4 | Per-lane inversion |
| pix_r | input | 8 | Red |
| pix_g | input | 8 | Green |
| pix_b | input | 8 | Blue |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable, active high at the input |
| pix_strobe | output | 1 | Pixel sample cycle |
| lane_data | output | 4 | Serial data lanes |
| lane_clk | output | 1 | Serial clock lane |

## Verification
The assertions assume that the pixel and configuration inputs are valid in the `pix_strobe` cycle. They also assume that the dither input range is a full byte, so a colour of 0xFF must saturate rather than wrap. The bench changes the pixel and every configuration input only at the start of a pixel period, so every value is stable by the strobe cycle. The bench also covers the saturating colour value, DE-low run restarts and inversions on lanes that the reorder has repeated.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOTS   = 7;
  localparam int LANES   = 4;
  localparam int COLOR_W = 8;
  localparam int FIELD_W = 6;
  localparam int SEL_W   = $clog2(LANES);

  typedef logic [SLOTS-1:0] word_t;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic hs;
    logic vs;
    logic de;
  } pixel_t;

  // slot 0 is transmitted first and lives in the top bit of a word
  localparam word_t CLK_WORD = 7'b1100011;

  function automatic word_t slots_to_word(input logic [SLOTS-1:0] s);
    word_t w;
    for (int i = 0; i < SLOTS; i++) w[SLOTS-1-i] = s[i];
    return w;
  endfunction

  // threshold order over four consecutive active pixels: 0,2,1,3
  function automatic logic [1:0] dither_thr(input logic [1:0] cnt);
    return {cnt[0], cnt[1]};
  endfunction

  function automatic logic [FIELD_W-1:0] dither6(input logic [COLOR_W-1:0] c,
                                                 input logic [1:0] cnt);
    logic [FIELD_W-1:0] hi;
    hi = c[COLOR_W-1:COLOR_W-FIELD_W];
    if ((c[1:0] > dither_thr(cnt)) && (hi != {FIELD_W{1'b1}})) return hi + 1'b1;
    return hi;
  endfunction
endpackage

// File: rtl/lvds_phase_gen.sv
module lvds_phase_gen
  import lvds_ser_pkg::*;
#(
  parameter int NSLOT = SLOTS
) (
  input  logic clk,
  input  logic rst_n,
  output logic load
);
  localparam int PH_W = $clog2(NSLOT);
  localparam logic [PH_W-1:0] LAST = PH_W'(NSLOT - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign load = (phase == LAST);

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (phase == '0));
endmodule

// File: rtl/lvds_bit_mapper.sv
module lvds_bit_mapper
  import lvds_ser_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  pixel_t pix,
  input  logic   fmt_alt,
  input  logic   depth_18,
  input  logic   dither_en,
  input  logic [2:0] sync_pol,
  output word_t [LANES-1:0] words
);
  logic [1:0] run_cnt;
  logic [FIELD_W-1:0] rh, gh, bh;
  logic [1:0] rl, gl, bl;
  logic hs_o, vs_o, de_o;
  logic use_dither;

  // position within the current run of active pixels, advanced per pixel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (load) run_cnt <= pix.de ? run_cnt + 1'b1 : 2'd0;
  end

  assign use_dither = depth_18 & dither_en;
  assign hs_o = pix.hs ^ sync_pol[0];
  assign vs_o = pix.vs ^ sync_pol[1];
  assign de_o = pix.de ^ sync_pol[2];

  always_comb begin
    if (use_dither) begin
      rh = dither6(pix.r, run_cnt);
      gh = dither6(pix.g, run_cnt);
      bh = dither6(pix.b, run_cnt);
    end else if (fmt_alt && !depth_18) begin
      rh = pix.r[FIELD_W-1:0];
      gh = pix.g[FIELD_W-1:0];
      bh = pix.b[FIELD_W-1:0];
    end else begin
      rh = pix.r[COLOR_W-1:COLOR_W-FIELD_W];
      gh = pix.g[COLOR_W-1:COLOR_W-FIELD_W];
      bh = pix.b[COLOR_W-1:COLOR_W-FIELD_W];
    end
    if (depth_18) begin
      rl = '0; gl = '0; bl = '0;
    end else if (fmt_alt) begin
      rl = pix.r[COLOR_W-1:FIELD_W];
      gl = pix.g[COLOR_W-1:FIELD_W];
      bl = pix.b[COLOR_W-1:FIELD_W];
    end else begin
      rl = pix.r[1:0];
      gl = pix.g[1:0];
      bl = pix.b[1:0];
    end
  end

  assign words[0] = slots_to_word({gh[0], rh});
  assign words[1] = slots_to_word({bh[1:0], gh[5:1]});
  assign words[2] = slots_to_word({de_o, vs_o, hs_o, bh[5:2]});
  assign words[3] = slots_to_word({1'b0, bl, gl, rl});

  // R10
  dither_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_dither |-> (({1'b0, rh} >= {1'b0, pix.r[7:2]}) &&
                    ({1'b0, rh} <= {1'b0, pix.r[7:2]} + 7'd1)));

  // R10
  dither_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_dither && pix.g == 8'hFF) |-> (gh == 6'h3F));
endmodule

// File: rtl/lvds_lane_router.sv
module lvds_lane_router
  import lvds_ser_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  word_t [NLANE-1:0]          words_in,
  input  logic  [NLANE*SEL_W-1:0]    order,
  input  logic  [NLANE-1:0]          inv,
  input  logic                       depth_18,
  output word_t [NLANE-1:0]          words_out
);
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [SEL_W-1:0] src;
    word_t picked;
    assign src    = order[k*SEL_W +: SEL_W];
    assign picked = words_in[src] ^ {SLOTS{inv[k]}};
    if (k == NLANE - 1) begin : g_last
      assign words_out[k] = depth_18 ? '0 : picked;
    end else begin : g_norm
      assign words_out[k] = picked;
    end
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
  import lvds_ser_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t din,
  output logic  sout
);
  word_t sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sh <= '0;
    else if (load) sh <= din;
    else           sh <= {sh[SLOTS-2:0], 1'b0};
  end

  assign sout = sh[SLOTS-1];
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_en,
  input  logic                   fmt_alt,
  input  logic                   depth_18,
  input  logic                   dither_en,
  input  logic [2:0]             sync_pol,
  input  logic [NLANE*SEL_W-1:0] lane_order,
  input  logic [NLANE-1:0]       lane_inv,
  input  logic [COLOR_W-1:0]     pix_r,
  input  logic [COLOR_W-1:0]     pix_g,
  input  logic [COLOR_W-1:0]     pix_b,
  input  logic                   pix_hs,
  input  logic                   pix_vs,
  input  logic                   pix_de,
  output logic                   pix_strobe,
  output logic [NLANE-1:0]       lane_data,
  output logic                   lane_clk
);
  logic   load;
  pixel_t pix;
  word_t [NLANE-1:0] mapped, routed, gated;
  word_t clk_word;

  assign pix = '{r: pix_r, g: pix_g, b: pix_b, hs: pix_hs, vs: pix_vs, de: pix_de};

  lvds_phase_gen #(.NSLOT(SLOTS)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(load)
  );

  lvds_bit_mapper u_map (
    .clk(clk), .rst_n(rst_n), .load(load), .pix(pix),
    .fmt_alt(fmt_alt), .depth_18(depth_18), .dither_en(dither_en),
    .sync_pol(sync_pol), .words(mapped)
  );

  lvds_lane_router #(.NLANE(NLANE)) u_route (
    .words_in(mapped), .order(lane_order), .inv(lane_inv),
    .depth_18(depth_18), .words_out(routed)
  );

  assign clk_word = tx_en ? CLK_WORD : '0;

  for (genvar k = 0; k < NLANE; k++) begin : g_ser
    assign gated[k] = tx_en ? routed[k] : '0;
    lvds_lane_shifter u_sh (
      .clk(clk), .rst_n(rst_n), .load(load), .din(gated[k]), .sout(lane_data[k])
    );
  end

  lvds_lane_shifter u_clk_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .din(clk_word), .sout(lane_clk)
  );

  assign pix_strobe = load;

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |=> !pix_strobe);

  // R3
  clk_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && tx_en) |=> lane_clk);

  // R6
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && depth_18) |=> !lane_data[NLANE-1]);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && !tx_en) |=> (lane_data == '0 && !lane_clk));
endmodule

// File: tb/tb_lvds_pixel_serializer.sv
`timescale 1ns/1ps
module tb_lvds_pixel_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, fmt_alt = 1'b0, depth_18 = 1'b0, dither_en = 1'b0;
  logic [2:0] sync_pol = '0;
  logic [7:0] lane_order = 8'hE4;
  logic [3:0] lane_inv = '0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic pix_strobe, lane_clk;
  logic [3:0] lane_data;

  always #2.5 clk = ~clk;

  lvds_pixel_serializer dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fmt_alt(fmt_alt),
    .depth_18(depth_18), .dither_en(dither_en), .sync_pol(sync_pol),
    .lane_order(lane_order), .lane_inv(lane_inv), .pix_r(pix_r),
    .pix_g(pix_g), .pix_b(pix_b), .pix_hs(pix_hs), .pix_vs(pix_vs),
    .pix_de(pix_de), .pix_strobe(pix_strobe), .lane_data(lane_data),
    .lane_clk(lane_clk)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int mphase = 0;
  int run = 0;
  bit exp_d[4][7];
  bit exp_c[7];
  string exp_req = "R1";
  string load_req = "R1";
  int thr[4] = '{0, 2, 1, 3};

  task automatic chk(input logic act, input logic expv, input string req, input int idx);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s signal %0d got %b exp %b", req, idx, act, expv);
    end
  endtask

  function automatic int six(input int c, input int k, input bit dith);
    int m = c / 4;
    if (dith && (c % 4) > thr[k] && m < 63) m++;
    return m;
  endfunction

  task automatic model_load();
    bit s[4][7];
    int rh, gh, bh, rl, gl, bl;
    bit hs, vs, de, dith;
    dith = depth_18 && dither_en;
    if (depth_18 || !fmt_alt) begin
      rh = six(pix_r, run, dith); gh = six(pix_g, run, dith); bh = six(pix_b, run, dith);
    end else begin
      rh = pix_r % 64; gh = pix_g % 64; bh = pix_b % 64;
    end
    if (depth_18) begin rl = 0; gl = 0; bl = 0; end
    else if (fmt_alt) begin rl = pix_r / 64; gl = pix_g / 64; bl = pix_b / 64; end
    else begin rl = pix_r % 4; gl = pix_g % 4; bl = pix_b % 4; end
    hs = pix_hs ^ sync_pol[0]; vs = pix_vs ^ sync_pol[1]; de = pix_de ^ sync_pol[2];
    for (int i = 0; i < 6; i++) s[0][i] = (rh >> i) & 1;
    s[0][6] = gh & 1;
    for (int i = 0; i < 5; i++) s[1][i] = (gh >> (i + 1)) & 1;
    s[1][5] = bh & 1; s[1][6] = (bh >> 1) & 1;
    for (int i = 0; i < 4; i++) s[2][i] = (bh >> (i + 2)) & 1;
    s[2][4] = hs; s[2][5] = vs; s[2][6] = de;
    s[3][0] = rl & 1; s[3][1] = (rl >> 1) & 1; s[3][2] = gl & 1;
    s[3][3] = (gl >> 1) & 1; s[3][4] = bl & 1; s[3][5] = (bl >> 1) & 1; s[3][6] = 0;
    for (int k = 0; k < 4; k++) begin
      int src = (lane_order >> (2 * k)) & 3;
      for (int i = 0; i < 7; i++) begin
        bit v = s[src][i] ^ lane_inv[k];
        if (depth_18 && k == 3) v = 0;
        if (!tx_en) v = 0;
        exp_d[k][i] = v;
      end
    end
    for (int i = 0; i < 7; i++) exp_c[i] = tx_en && (i < 2 || i > 4);
    run = pix_de ? (run + 1) % 4 : 0;
    exp_req = load_req;
  endtask

  task automatic step();
    for (int l = 0; l < 4; l++) chk(lane_data[l], exp_d[l][mphase], exp_req, l);
    chk(lane_clk, exp_c[mphase], "R3", 4);
    chk(pix_strobe, mphase == 6, "R2", 5);
    if (mphase == 6) model_load();
    mphase = (mphase + 1) % 7;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                      input logic hs, input logic vs, input logic de, input string req);
    bit done = 0;
    pix_r = r; pix_g = g; pix_b = b; pix_hs = hs; pix_vs = vs; pix_de = de;
    load_req = req;
    while (!done) begin
      done = (mphase == 6);
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) begin
      exp_c[i] = 0;
      for (int k = 0; k < 4; k++) exp_d[k][i] = 0;
    end
    repeat (3) begin
      @(negedge clk);
      chk(lane_data[0] | lane_data[1] | lane_data[2] | lane_data[3], 1'b0, "R1", 0);
      chk(lane_clk, 1'b0, "R1", 4);
      chk(pix_strobe, 1'b0, "R1", 5);
    end
    rst_n = 1'b1;
    // R1: first pixel sampled with tx_en low, so outputs stay zero
    send(8'hFF, 8'hFF, 8'hFF, 1, 1, 1, "R11");
    tx_en = 1'b1;
    // R4 standard mapping, several patterns
    send(8'hA5, 8'h3C, 8'h81, 0, 1, 1, "R4");
    send(8'h01, 8'h02, 8'h80, 1, 0, 0, "R4");
    send(8'hFF, 8'h00, 8'h55, 1, 1, 1, "R4");
    // R5 alternative mapping
    fmt_alt = 1'b1;
    send(8'hC3, 8'h5A, 8'h7E, 0, 1, 0, "R5");
    send(8'h40, 8'h80, 8'h3F, 1, 0, 1, "R5");
    // R6 18-bit ignores the mapping selector and idles lane 3
    depth_18 = 1'b1;
    send(8'hC3, 8'h5A, 8'h7E, 1, 1, 1, "R6");
    fmt_alt = 1'b0;
    lane_inv = 4'h8;
    send(8'h3F, 8'hC0, 8'hFF, 0, 0, 1, "R6");
    lane_inv = 4'h0;
    depth_18 = 1'b0;
    // R7 polarity, each bit alone then all
    sync_pol = 3'b001; send(8'h12, 8'h34, 8'h56, 1, 0, 1, "R7");
    sync_pol = 3'b010; send(8'h12, 8'h34, 8'h56, 1, 0, 1, "R7");
    sync_pol = 3'b100; send(8'h12, 8'h34, 8'h56, 1, 0, 1, "R7");
    sync_pol = 3'b111; send(8'h12, 8'h34, 8'h56, 0, 1, 0, "R7");
    sync_pol = 3'b000;
    // R8 reorder: reversed, then all from lane 2
    lane_order = 8'h1B; send(8'hA5, 8'h3C, 8'h81, 0, 1, 1, "R8");
    lane_order = 8'hAA; send(8'h5A, 8'hC3, 8'h18, 1, 0, 1, "R8");
    // R9 inversion after reorder
    lane_inv = 4'h5; send(8'h5A, 8'hC3, 8'h18, 1, 0, 1, "R9");
    lane_order = 8'hE4;
    lane_inv = 4'hA; send(8'h00, 8'hFF, 8'h0F, 0, 0, 0, "R9");
    lane_inv = 4'h0;
    // R10 dither: 24-bit mode unaffected, then a DE run with restart
    dither_en = 1'b1;
    send(8'h07, 8'h0B, 8'h0E, 0, 0, 1, "R10");
    send(8'h00, 8'h00, 8'h00, 0, 0, 0, "R10");
    depth_18 = 1'b1;
    for (int p = 0; p < 5; p++) send(8'h07, 8'hFF, 8'h0A, 0, 0, 1, "R10");
    send(8'h07, 8'hFF, 8'h0A, 0, 0, 0, "R10");
    send(8'h06, 8'hFE, 8'h0B, 0, 0, 1, "R10");
    send(8'h06, 8'hFE, 8'h0B, 0, 0, 1, "R10");
    dither_en = 1'b0; depth_18 = 1'b0;
    // R11 disable mid-stream, then re-enable
    tx_en = 1'b0; send(8'hFF, 8'hFF, 8'hFF, 1, 1, 1, "R11");
    tx_en = 1'b1; send(8'h96, 8'h69, 8'hF0, 1, 1, 1, "R2");
    tx_en = 1'b0; send(8'h00, 8'h00, 8'h00, 0, 0, 0, "R11");
    send(8'h00, 8'h00, 8'h00, 0, 0, 0, "R11");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule